// File: doc/BRIEF.md
# SDRAM Burst Read/Write Sequencer

This block turns one request from a processor-side agent into a complete burst on a synchronous DRAM. Each request carries a row, a starting column and a direction. The sequencer first opens the row with an activate command. After a fixed activate-to-column delay it issues a single read or write command carrying the starting column. It then streams the whole burst. During the burst it steps the column by itself and raises a per-word strobe toward the requester. All device pins change on the clock. The command pins are decoded from registered state.

The burst length is held in a small mode register. The requester programs it with a two-bit code, and the sequencer forwards that code to the device in a one-cycle mode-set command. Reads return their first word one clock after the column command, and further words follow on consecutive clocks. Writes take one word per clock, starting in the cycle of the column command itself. The column counter wraps inside the aligned block of one burst length, so a burst never leaves that block or the open row. While any operation is in progress, `busy` is high and new requests and mode writes are not taken.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `wr_ready` and `sd_dq_oe` are 0. The device pins show deselect (`sd_cs_n`, `sd_ras_n`, `sd_cas_n` and `sd_we_n` all 1). The burst length is 4 (code 2).
- R2: A mode write (`mode_we`=1) taken while idle is followed in the next cycle by one mode-set command, with `sd_cs_n`, `sd_ras_n`, `sd_cas_n` and `sd_we_n` all 0 and `sd_addr` equal to the code. Codes 0, 1, 2 and 3 select burst lengths 1, 2, 4 and 8 for every later burst.
- R3: A mode write presented while `busy` is 1 is ignored. Later bursts keep the previously programmed length.
- R4: A request accepted while idle produces an activate command in the next cycle: `sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=1, `sd_we_n`=1 and `sd_addr`=row. `busy` is 1 from that cycle on.
- R5: The column command comes exactly TRCD cycles after the activate, with no-operation commands (`sd_cs_n`=0, others 1) in between. The column command has `sd_ras_n`=1 and `sd_cas_n`=0. It has `sd_we_n`=0 for a write and 1 for a read, with `sd_addr` equal to the starting column.
- R6: On a read, `rd_valid` is 1 for exactly BL consecutive cycles, beginning one cycle after the column command. `rd_data` carries `sd_dq_in` in those cycles.
- R7: On a write, `wr_ready` and `sd_dq_oe` are 1 for exactly BL consecutive cycles, beginning in the column-command cycle. `sd_dq_out` carries `wr_data`, and the words land in consecutive burst columns.
- R8: In beat k of a burst that starts at column S, `sd_addr` is (S & ~(BL-1)) | ((S+k) & (BL-1)), so the burst wraps inside its aligned block. Every beat after the column command is a no-operation command.
- R9: `busy` returns to 0 in the cycle after the last beat. A request presented while `busy` is 1 is dropped and produces no activate.
- R10: If a mode write and a request arrive together while idle, the mode write is taken and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_code | input | 2 | Burst length code: 0→1, 1→2, 2→4, 3→8 |
| req_valid | input | 1 | Burst request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column |
| busy | output | 1 | Operation in progress; inputs not taken |
| wr_data | input | DATA_W | Write word for the current beat |
| wr_ready | output | 1 | Write beat strobe: `wr_data` is consumed this cycle |
| rd_data | output | DATA_W | Read word |
| rd_valid | output | 1 | Read beat strobe |
| sd_cs_n | output | 1 | Device select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | max(ROW_W,COL_W) | Multiplexed row / column / mode code |
| sd_dq_out | output | DATA_W | Data toward device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DATA_W | Data from device |

## Verification
The bench builds the sequencer with 3 row bits, 4 column bits, 8 data bits and TRCD of 2. A 128-word memory model and its shadow then stay small. The bench reads every one of the 16 starting columns under all four burst lengths, so every wrap position inside an aligned block occurs, including the length-8 wrap that crosses half the row. It also writes and reads back across all lengths. The mode-write and request hold-off paths are driven in the gap between activate and column command.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Largest burst is 2**BL_LOG_MAX words; the code selects 2**code.
  localparam int BL_LOG_MAX = 3;
  localparam int CODE_W     = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MODE,
    ST_ACT,
    ST_WAIT,
    ST_COL,
    ST_DATA
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_DESEL = sd_cmd_t'(4'b1111);
  localparam sd_cmd_t CMD_NOP   = sd_cmd_t'(4'b0111);
  localparam sd_cmd_t CMD_ACT   = sd_cmd_t'(4'b0011);
  localparam sd_cmd_t CMD_RD    = sd_cmd_t'(4'b0101);
  localparam sd_cmd_t CMD_WR    = sd_cmd_t'(4'b0100);
  localparam sd_cmd_t CMD_MODE  = sd_cmd_t'(4'b0000);

endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
  import sbs_pkg::*;
#(
  parameter logic [CODE_W-1:0] RST_CODE = 2'd2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [CODE_W-1:0]     code_i,
  input  logic                  busy_i,
  output logic [CODE_W-1:0]     code_o,
  output logic [BL_LOG_MAX-1:0] mask_o
);

  logic              load;
  logic [CODE_W-1:0] code_q, code_d;

  // Only an idle sequencer may take a new length.
  assign load = wr_en_i & ~busy_i;

  always_comb begin
    code_d = code_q;
    if (load) code_d = code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= RST_CODE;
    else        code_q <= code_d;
  end

  // Low mask bits equal burst length minus one.
  for (genvar i = 0; i < BL_LOG_MAX; i++) begin : g_mask
    assign mask_o[i] = (int'(code_q) > i);
  end

  assign code_o = code_q;

  a_r3_code_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(code_q));

endmodule

// File: rtl/sbs_col_ctr.sv
module sbs_col_ctr
  import sbs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [COL_W-1:0]      start_i,
  input  logic                  step_i,
  input  logic [BL_LOG_MAX-1:0] mask_i,
  output logic [COL_W-1:0]      col_o
);

  logic [COL_W-1:0] col_q, col_d, wmask, col_inc;

  assign wmask   = COL_W'(mask_i);
  assign col_inc = col_q + COL_W'(1);

  always_comb begin
    col_d = col_q;
    if (load_i)      col_d = start_i;
    else if (step_i) col_d = (col_q & ~wmask) | (col_inc & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= col_d;
  end

  assign col_o = col_q;

  a_r8_wrap_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> ((col_q & ~$past(wmask)) == ($past(col_q) & ~$past(wmask))));

endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int TRCD = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_we_i,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [BL_LOG_MAX-1:0] last_beat_i,
  output seq_state_e            state_o,
  output logic                  write_o,
  output logic                  accept_o,
  output logic                  col_step_o,
  output logic                  busy_o
);

  localparam int WAIT_W = (TRCD > 2) ? $clog2(TRCD) : 1;

  seq_state_e            state_q, state_d;
  logic                  wr_q, wr_d;
  logic [WAIT_W-1:0]     wait_q, wait_d;
  logic [BL_LOG_MAX-1:0] beat_q, beat_d;
  logic                  idle;

  assign idle     = (state_q == ST_IDLE);
  assign accept_o = idle & req_valid_i & ~mode_we_i;

  always_comb begin
    state_d = state_q;
    wr_d    = wr_q;
    wait_d  = wait_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: begin
        if (mode_we_i) begin
          state_d = ST_MODE;
        end else if (req_valid_i) begin
          state_d = ST_ACT;
          wr_d    = req_write_i;
        end
      end
      ST_MODE: state_d = ST_IDLE;
      ST_ACT: begin
        wait_d  = '0;
        state_d = (TRCD > 1) ? ST_WAIT : ST_COL;
      end
      ST_WAIT: begin
        wait_d = wait_q + WAIT_W'(1);
        if (int'(wait_q) == TRCD - 2) state_d = ST_COL;
      end
      ST_COL: begin
        if (wr_q) begin
          // Beat 0 of a write happens in this cycle.
          if (last_beat_i == '0) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_DATA;
            beat_d  = BL_LOG_MAX'(1);
          end
        end else begin
          state_d = ST_DATA;
          beat_d  = '0;
        end
      end
      ST_DATA: begin
        if (beat_q == last_beat_i) state_d = ST_IDLE;
        else                       beat_d  = beat_q + BL_LOG_MAX'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      wait_q  <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      wait_q  <= wait_d;
      beat_q  <= beat_d;
    end
  end

  assign state_o    = state_q;
  assign write_o    = wr_q;
  assign busy_o     = ~idle;
  assign col_step_o = (state_q == ST_DATA) | ((state_q == ST_COL) & wr_q);

  a_r9_no_act_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_ACT));

  a_r5_col_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COL) |-> ($past(state_q) == ((TRCD > 1) ? ST_WAIT : ST_ACT)));

  a_r6_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (beat_q <= last_beat_i));

  a_r10_mode_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && mode_we_i) |=> (state_q == ST_MODE));

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int                ROW_W    = 13,
  parameter int                COL_W    = 10,
  parameter int                DATA_W   = 16,
  parameter int                TRCD     = 2,
  parameter logic [CODE_W-1:0] RST_CODE = 2'd2,
  localparam int               ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [CODE_W-1:0] mode_code,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              busy,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);

  seq_state_e            state;
  logic                  is_wr, accept, col_step;
  logic [BL_LOG_MAX-1:0] mask;
  logic [CODE_W-1:0]     code;
  logic [COL_W-1:0]      col;
  logic [ROW_W-1:0]      row_q, row_d;
  sd_cmd_t               cmd;

  sbs_ctrl #(.TRCD(TRCD)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_we_i   (mode_we),
    .req_valid_i (req_valid),
    .req_write_i (req_write),
    .last_beat_i (mask),
    .state_o     (state),
    .write_o     (is_wr),
    .accept_o    (accept),
    .col_step_o  (col_step),
    .busy_o      (busy)
  );

  sbs_mode_reg #(.RST_CODE(RST_CODE)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (mode_we),
    .code_i  (mode_code),
    .busy_i  (busy),
    .code_o  (code),
    .mask_o  (mask)
  );

  sbs_col_ctr #(.COL_W(COL_W)) u_col (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .start_i (req_col),
    .step_i  (col_step),
    .mask_i  (mask),
    .col_o   (col)
  );

  always_comb begin
    row_d = row_q;
    if (accept) row_d = req_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  always_comb begin
    cmd     = CMD_DESEL;
    sd_addr = '0;
    unique case (state)
      ST_MODE: begin cmd = CMD_MODE; sd_addr = ADDR_W'(code);  end
      ST_ACT:  begin cmd = CMD_ACT;  sd_addr = ADDR_W'(row_q); end
      ST_WAIT: begin cmd = CMD_NOP; end
      ST_COL:  begin cmd = is_wr ? CMD_WR : CMD_RD; sd_addr = ADDR_W'(col); end
      ST_DATA: begin cmd = CMD_NOP;  sd_addr = ADDR_W'(col);   end
      default: begin cmd = CMD_DESEL; end
    endcase
  end

  assign sd_cs_n   = cmd.cs_n;
  assign sd_ras_n  = cmd.ras_n;
  assign sd_cas_n  = cmd.cas_n;
  assign sd_we_n   = cmd.we_n;

  assign wr_ready  = is_wr & ((state == ST_COL) | (state == ST_DATA));
  assign rd_valid  = ~is_wr & (state == ST_DATA);
  assign sd_dq_oe  = wr_ready;
  assign sd_dq_out = wr_data;
  assign rd_data   = sd_dq_in;

  a_r7_oe_not_on_row_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (sd_ras_n && !sd_cs_n));

  a_r4_act_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_ras_n && sd_cas_n) |-> busy);

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, wr_ready, !sd_ras_n}));

endmodule

// File: tb/sdram_burst_seq_tb.sv
`timescale 1ns/1ps
module sdram_burst_seq_tb;

  localparam int ROW_W = 3, COL_W = 4, DATA_W = 8, TRCD = 2, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 0; logic [1:0] mode_code = 0;
  logic req_valid = 0, req_write = 0;
  logic [ROW_W-1:0] req_row = 0; logic [COL_W-1:0] req_col = 0;
  logic [DATA_W-1:0] wr_data = 0;
  logic busy, wr_ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [DATA_W-1:0] rd_data, sd_dq_out, sd_dq_in;
  logic [AW-1:0] sd_addr;

  int checks = 0, errors = 0, bl = 4;
  logic [7:0] shadow [0:127];

  always #2 clk = ~clk;

  sdram_burst_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .TRCD(TRCD)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_code(mode_code),
    .req_valid(req_valid), .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .busy(busy), .wr_data(wr_data), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in)
  );

  // Behavioural device model: latches row, column, steps within the burst block.
  logic [7:0] mem [0:127];
  int m_bl = 4, m_left = 0;
  logic [2:0] m_row = 0;
  logic [3:0] m_col = 0;

  function automatic logic [3:0] wrap_next(input logic [3:0] c, input int len);
    return 4'((int'(c) & ~(len - 1)) | ((int'(c) + 1) & (len - 1)));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'((i * 37 + 11) & 255);
      m_bl <= 4; m_left <= 0;
    end else if (!sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n) begin
      m_bl <= 1 << sd_addr[1:0];
    end else if (!sd_cs_n && !sd_ras_n) begin
      m_row <= sd_addr[2:0];
    end else if (!sd_cs_n && !sd_cas_n) begin
      if (!sd_we_n) begin
        mem[{m_row, sd_addr[3:0]}] <= sd_dq_out;
        m_col  <= wrap_next(sd_addr[3:0], m_bl);
        m_left <= m_bl - 1;
      end else begin
        m_col  <= sd_addr[3:0];
        m_left <= m_bl;
      end
    end else if (m_left > 0) begin
      if (sd_dq_oe) mem[{m_row, m_col}] <= sd_dq_out;
      m_col  <= wrap_next(m_col, m_bl);
      m_left <= m_left - 1;
    end
  end

  assign sd_dq_in = mem[{m_row, m_col}];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int beat_col(input int s, input int k, input int len);
    return (s & ~(len - 1)) | ((s + k) & (len - 1));
  endfunction

  task automatic set_mode(input int code);
    mode_we = 1; mode_code = 2'(code);
    @(negedge clk);
    chk("R2 mode cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 0);
    chk("R2 mode code", int'(sd_addr), code);
    mode_we = 0;
    bl = 1 << code;
    @(negedge clk);
    chk("R2 idle after mode", busy, 0);
  endtask

  // inj: 0 none, 1 mode write while busy, 2 request while busy
  task automatic burst(input bit wr, input int row, input int col, input int seed, input int inj);
    req_valid = 1; req_write = wr; req_row = 3'(row); req_col = 4'(col);
    @(negedge clk);
    chk("R4 act cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0011);
    chk("R4 act row", int'(sd_addr), row);
    chk("R4 busy", busy, 1);
    req_valid = 0;
    for (int w = 1; w < TRCD; w++) begin
      @(negedge clk);
      chk("R5 gap nop", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
      if (w == 1 && inj == 1) begin mode_we = 1; mode_code = 2'd3; end
      if (w == 1 && inj == 2) begin req_valid = 1; req_row = 3'(row + 1); end
    end
    @(negedge clk);
    mode_we = 0; req_valid = 0;
    chk("R5 col cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, wr ? 4'b0100 : 4'b0101);
    chk("R5 col addr", int'(sd_addr), col);
    for (int k = 0; k < bl; k++) begin
      int c;
      c = beat_col(col, k, bl);
      if (wr) begin
        if (k > 0) begin
          @(negedge clk);
          chk("R8 beat nop", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        end
        chk("R7 wr_ready", wr_ready, 1);
        chk("R7 dq_oe", sd_dq_oe, 1);
        chk("R8 wr col", int'(sd_addr), c);
        wr_data = 8'((seed * 29 + k * 13 + 7) & 255);
        shadow[row * 16 + c] = wr_data;
      end else begin
        @(negedge clk);
        chk("R6 rd_valid", rd_valid, 1);
        chk("R8 rd col", int'(sd_addr), c);
        chk("R6 rd_data", int'(rd_data), int'(shadow[row * 16 + c]));
      end
    end
    @(negedge clk);
    chk("R9 busy end", busy, 0);
    chk("R6 rd end", rd_valid, 0);
    chk("R7 wr end", wr_ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) shadow[i] = 8'((i * 37 + 11) & 255);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b1111);
    chk("R1 strobes", {rd_valid, wr_ready, sd_dq_oe}, 0);
    // R1: default length 4, wraps 5,6,7,4
    burst(0, 1, 5, 0, 0);

    for (int code = 0; code < 4; code++) begin
      set_mode(code);
      for (int c = 0; c < 16; c++) burst(0, c % 8, c, 0, 0);
    end
    for (int code = 0; code < 4; code++) begin
      set_mode(code);
      for (int c = 0; c < 16; c += 3) begin
        burst(1, (c + code) % 8, c, c + code * 5, 0);
        burst(0, (c + code) % 8, c, 0, 0);
      end
    end

    // R3: mode write during busy is ignored
    set_mode(1);
    burst(0, 2, 3, 0, 1);
    burst(0, 4, 7, 0, 0);

    // R9: request during busy is dropped
    burst(0, 5, 9, 0, 2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 no act", sd_ras_n, 1);
      chk("R9 idle", busy, 0);
    end

    // R10: mode write beats simultaneous request
    mode_we = 1; mode_code = 2'd0; req_valid = 1; req_row = 3'd6; req_col = 4'd2; req_write = 0;
    @(negedge clk);
    chk("R10 mode first", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 0);
    mode_we = 0; req_valid = 0; bl = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 req dropped", sd_ras_n, 1);
    end
    burst(0, 6, 2, 0, 0);
    burst(1, 6, 2, 99, 0);
    burst(0, 6, 2, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule